// File: doc/BRIEF.md
# Twelve-Hour BCD Hours Counter with Meridiem Flag

This block holds the hours part of a 12-hour wall clock: a one-bit tens digit, a four-bit BCD units digit and a morning/afternoon flag. It runs on a single system clock. Every state change is gated by one of two one-cycle enables. The advance enable moves the hour forward by one. It is pulsed by the minutes stage when that stage wraps from 59 to 00, or by a set-mode request from the user. The toggle enable flips only the meridiem flag and leaves the hour alone.

The hour sequence is 01, 02, ... 09, 10, 11, 12, then 01 again. The value 00 never appears. The meridiem flag inverts on each advance that goes from 12 to 01. The tens digit is also presented as a full BCD nibble whose upper three bits are zero, so it can drive a standard digit decoder directly.

Top module: `twelve_hour_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the hour to 12 (tens=1, units=2) and the flag to 0 (0 = AM, 1 = PM).
- R2: With the hour from 01 to 08, an advance raises units by one and leaves tens at 0.
- R3: An advance at 09 (tens=0, units=9) gives 10 (tens=1, units=0).
- R4: Advances at 10 and at 11 give 11 and 12.
- R5: An advance at 12 gives 01 (tens=0, units=1). No reachable state has tens=0 and units=0, and units never exceeds 9.
- R6: The flag inverts on an advance from 12 to 01 and on no other advance, so 24 consecutive advances flip it exactly twice.
- R7: A toggle without an advance inverts the flag and leaves the hour unchanged.
- R8: When advance and toggle arrive in the same cycle, the hour advances normally and the toggle inverts the flag after any wrap flip. At 12, both together give 01 with the flag unchanged. At other hours, both together advance the hour and invert the flag.
- R9: With both enables low, the hour and the flag hold their values.
- R10: tensBcd equals {3'b000, tensDigit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advanceEn | input | 1 | One-cycle request to advance the hour |
| toggleEn | input | 1 | One-cycle request to invert the meridiem flag |
| tensDigit | output | 1 | Tens-of-hours digit (0 or 1) |
| tensBcd | output | 4 | Tens digit as a BCD nibble, upper bits zero |
| unitsDigit | output | UNITS_W (4) | Units-of-hours digit, BCD |
| pmFlag | output | 1 | Meridiem flag, 1 = PM |

## Verification
The wrap from 12 to 01 inverts the flag. A toggle request can land in that same cycle, and the two flips must cancel. The bench steers the count to 12 and then asserts advance and toggle together in one cycle. The scoreboard expects 01 with the flag unchanged. The bench also asserts both enables together at an hour that does not wrap, and there it expects a single inversion.

// File: rtl/hour12_pkg.sv
package hour12_pkg;

  // Strobes issued by the control to the datapath for one clock cycle.
  typedef struct packed {
    logic stepUnits;     // units + 1, tens unchanged
    logic rollTens;      // units -> 0, tens -> 1 (09 -> 10)
    logic wrapToOne;     // units -> 1, tens -> 0 (12 -> 01)
    logic flipMeridiem;  // invert the flag
  } hourStrobes_t;

  localparam int unsigned UNIT_LAST   = 9;  // last units value before rolling
  localparam int unsigned TOP_UNITS   = 2;  // units value of hour 12
  localparam int unsigned WRAP_UNITS  = 1;  // units value after 12
  localparam int unsigned RESET_UNITS = 2;  // reset shows 12

endpackage

// File: rtl/hour12_ctrl.sv
module hour12_ctrl
  import hour12_pkg::*;
#(
  parameter int unsigned UNITS_W = 4
) (
  input  logic               advanceEn,
  input  logic               toggleEn,
  input  logic               tensQ,
  input  logic [UNITS_W-1:0] unitsQ,
  output hourStrobes_t       strobes
);

  localparam logic [UNITS_W-1:0] LAST_U = UNITS_W'(UNIT_LAST);
  localparam logic [UNITS_W-1:0] TOP_U  = UNITS_W'(TOP_UNITS);

  logic atTop;
  logic atNine;

  assign atTop  = tensQ && (unitsQ == TOP_U);
  assign atNine = !tensQ && (unitsQ == LAST_U);

  always_comb begin
    strobes              = '0;
    strobes.wrapToOne    = advanceEn && atTop;
    strobes.rollTens     = advanceEn && atNine;
    strobes.stepUnits    = advanceEn && !atTop && !atNine;
    // the toggle is applied after the wrap flip, so the two cancel
    strobes.flipMeridiem = (advanceEn && atTop) ^ toggleEn;
  end

endmodule

// File: rtl/hour12_datapath.sv
module hour12_datapath
  import hour12_pkg::*;
#(
  parameter int unsigned UNITS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  hourStrobes_t       strobes,
  output logic               tensQ,
  output logic [UNITS_W-1:0] unitsQ,
  output logic               pmQ
);

  localparam logic [UNITS_W-1:0] RST_U  = UNITS_W'(RESET_UNITS);
  localparam logic [UNITS_W-1:0] WRAP_U = UNITS_W'(WRAP_UNITS);
  localparam logic [UNITS_W-1:0] ONE_U  = UNITS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tensQ  <= 1'b1;
      unitsQ <= RST_U;
      pmQ    <= 1'b0;
    end else begin
      if (strobes.wrapToOne) begin
        tensQ  <= 1'b0;
        unitsQ <= WRAP_U;
      end else if (strobes.rollTens) begin
        tensQ  <= 1'b1;
        unitsQ <= '0;
      end else if (strobes.stepUnits) begin
        unitsQ <= unitsQ + ONE_U;
      end
      if (strobes.flipMeridiem) begin
        pmQ <= ~pmQ;
      end
    end
  end

  AST_ROLL_TENS: assert property (@(posedge clk) disable iff (rst)
    strobes.rollTens |=> (tensQ && unitsQ == '0)); // R3

  AST_WRAP_ONE: assert property (@(posedge clk) disable iff (rst)
    strobes.wrapToOne |=> (!tensQ && unitsQ == WRAP_U)); // R5

  AST_STEP_KEEPS_TENS: assert property (@(posedge clk) disable iff (rst)
    strobes.stepUnits |=> (tensQ == $past(tensQ) && unitsQ == $past(unitsQ) + ONE_U)); // R2

  AST_FLAG_FLIP: assert property (@(posedge clk) disable iff (rst)
    strobes.flipMeridiem |=> (pmQ != $past(pmQ))); // R6

endmodule

// File: rtl/twelve_hour_counter.sv
module twelve_hour_counter
  import hour12_pkg::*;
#(
  parameter int unsigned UNITS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advanceEn,
  input  logic               toggleEn,
  output logic               tensDigit,
  output logic [3:0]         tensBcd,
  output logic [UNITS_W-1:0] unitsDigit,
  output logic               pmFlag
);

  localparam logic [UNITS_W-1:0] TOP_U = UNITS_W'(TOP_UNITS);
  localparam logic [UNITS_W-1:0] MAX_U = UNITS_W'(UNIT_LAST);

  hourStrobes_t strobes;
  logic         tensQ;
  logic [UNITS_W-1:0] unitsQ;
  logic         pmQ;

  hour12_ctrl #(.UNITS_W(UNITS_W)) u_ctrl (
    .advanceEn (advanceEn),
    .toggleEn  (toggleEn),
    .tensQ     (tensQ),
    .unitsQ    (unitsQ),
    .strobes   (strobes)
  );

  hour12_datapath #(.UNITS_W(UNITS_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .tensQ   (tensQ),
    .unitsQ  (unitsQ),
    .pmQ     (pmQ)
  );

  assign tensDigit  = tensQ;
  assign tensBcd    = {3'b000, tensQ};
  assign unitsDigit = unitsQ;
  assign pmFlag     = pmQ;

  AST_RESET_TWELVE: assert property (@(posedge clk)
    rst |=> (tensDigit && unitsDigit == TOP_U && !pmFlag)); // R1

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !(tensDigit == 1'b0 && unitsDigit == '0)); // R5

  AST_UNITS_RANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (unitsDigit <= MAX_U && (!tensDigit || unitsDigit <= TOP_U))); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!advanceEn && !toggleEn) |=> ($stable(tensDigit) && $stable(unitsDigit) && $stable(pmFlag))); // R9

  AST_TOGGLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (toggleEn && !advanceEn) |=> ($stable(unitsDigit) && $stable(tensDigit) && pmFlag != $past(pmFlag))); // R7

  AST_BOTH_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    (advanceEn && toggleEn && tensDigit && unitsDigit == TOP_U) |=> $stable(pmFlag)); // R8

endmodule

// File: tb/twelve_hour_counter_bench.sv
module twelve_hour_counter_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       advanceEn = 1'b0;
  logic       toggleEn = 1'b0;
  logic       tensDigit;
  logic [3:0] tensBcd;
  logic [3:0] unitsDigit;
  logic       pmFlag;

  twelve_hour_counter u_twelve_hour_counter (
    .clk        (clk),
    .rst        (rst),
    .advanceEn  (advanceEn),
    .toggleEn   (toggleEn),
    .tensDigit  (tensDigit),
    .tensBcd    (tensBcd),
    .unitsDigit (unitsDigit),
    .pmFlag     (pmFlag)
  );

  typedef struct {
    int    hr;
    bit    pm;
    string tag;
  } expItem_t;

  expItem_t scb[$];
  int  errors = 0;
  int  checks = 0;
  int  mHour = 12;
  bit  mPm = 1'b0;
  bit  counting = 1'b0;
  int  flips = 0;
  bit  lastPm = 1'b0;
  bit  finished = 1'b0;

  // Driver: one cycle of stimulus, expected result pushed for the next edge.
  task automatic step(input bit r, input bit adv, input bit tog, input string tag);
    @(negedge clk);
    rst = r;
    advanceEn = adv;
    toggleEn = tog;
    if (r) begin
      mHour = 12;
      mPm = 1'b0;
    end else begin
      if (adv) begin
        if (mHour == 12) begin
          mHour = 1;
          mPm = ~mPm;
        end else begin
          mHour = mHour + 1;
        end
      end
      if (tog) mPm = ~mPm;
    end
    scb.push_back('{mHour, mPm, tag});
  endtask

  function automatic string advTag(input int cur);
    if (cur == 12) return "R5/R6 wrap 12->01";
    if (cur == 9) return "R3 09->10";
    if (cur >= 10) return "R4 10s step";
    return "R2 units step";
  endfunction

  // Monitor: compares each result 2 ns after the edge that produced it.
  initial begin
    expItem_t e;
    int expTens;
    int expUnits;
    forever begin
      @(posedge clk);
      #2;
      if (counting && pmFlag != lastPm) flips++;
      lastPm = pmFlag;
      if (scb.size() > 0) begin
        e = scb.pop_front();
        expTens = (e.hr >= 10) ? 1 : 0;
        expUnits = e.hr % 10;
        checks++;
        if (int'(tensDigit) != expTens || int'(unitsDigit) != expUnits || pmFlag != e.pm) begin
          errors++;
          $display("FAIL %s: got %0d%0d pm=%0d, expected %0d%0d pm=%0d",
                   e.tag, tensDigit, unitsDigit, pmFlag, expTens, expUnits, e.pm);
        end
        checks++;
        if (tensBcd != {3'b000, tensDigit} || int'(tensBcd) != expTens) begin
          errors++;
          $display("FAIL R10 tensBcd: got %0d, expected %0d", tensBcd, expTens);
        end
      end
    end
  end

  initial begin
    step(1'b1, 1'b0, 1'b0, "R1 reset to 12 AM");
    step(1'b0, 1'b0, 1'b0, "R9 hold idle");
    step(1'b0, 1'b0, 1'b0, "R9 hold idle");
    counting = 1'b1;
    for (int i = 0; i < 24; i++) begin
      step(1'b0, 1'b1, 1'b0, advTag(mHour));
    end
    step(1'b0, 1'b0, 1'b0, "R9 hold after sweep");
    repeat (2) @(negedge clk);
    counting = 1'b0;
    checks++;
    if (flips != 2) begin
      errors++;
      $display("FAIL R6 flag changes over 24 advances: got %0d, expected 2", flips);
    end
    // now at 12 AM
    step(1'b0, 1'b0, 1'b1, "R7 toggle alone at 12");
    step(1'b0, 1'b0, 1'b1, "R7 toggle alone back");
    step(1'b0, 1'b1, 1'b1, "R8 both at 12");
    step(1'b0, 1'b1, 1'b1, "R8 both at 01");
    step(1'b0, 1'b0, 1'b0, "R9 hold after both");
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 1'b1, 1'b0, advTag(mHour));
    end
    step(1'b0, 1'b0, 1'b1, "R7 toggle alone at 09");
    step(1'b0, 1'b1, 1'b1, "R8 both at 09");
    step(1'b1, 1'b1, 1'b1, "R1 reset beats enables");
    step(1'b0, 1'b0, 1'b0, "R9 hold after reset");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule